// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is a register-controlled I/O port for eight pins. Software-side logic reaches it through a small synchronous register interface with an address, a write strobe, write data and read data. The port has two registers. A 16-bit configuration word gives each pin a direction bit and a pull-up bit, placed side by side. An 8-bit output latch holds the value that each output pin drives. The block sends per-pin output-enable, output-value and pull-up-enable signals to the pad cells.

Pin levels come back through a two-stage synchronizer. A read of the data offset returns these synchronized levels, not the latch contents. Reset clears only the configuration word. The output latch keeps whatever was last written to it.

The register interface accepts a write in every cycle and never stalls. It carries no valid/ready pair and applies no back-pressure. Writes take effect on the rising clock edge. Read data is a combinational function of the address. A status flag reports any pin that is driving while its pull-up is on. That setting wastes power and should be avoided.

Top module: `gpio_port8`

## Requirements
- R1: The configuration word sits at offset 0. Bit 2n is the direction of pin n and bit 2n+1 is the pull-up control of pin n.
- R2: Asynchronous active-low reset clears the configuration word to 0. After reset every pin is an input (pad_oe = 0x00), every pull-up is on (pad_pu_en = 0xFF), and a read of offset 0 returns 0x0000.
- R3: pad_oe[n] is 1 exactly when direction bit 2n is 1, which makes pin n an output. A value of 0 makes it an input.
- R4: pad_pu_en[n] is the inverse of bit 2n+1, so a 0 in that bit enables the pull-up. The direction bit has no effect on it.
- R5: A write to offset 2 loads bus_wdata[7:0] into the output latch, and pad_out shows it after that clock edge. Bits 15:8 of the write are ignored.
- R6: A read of offset 2 returns the pin_in levels from two rising edges earlier in bits 7:0 and zero in bits 15:8. It never returns the latch value.
- R7: Reset leaves the output latch unchanged, so pad_out keeps its last written value through reset.
- R8: Odd offsets 1 and 3 read as 0x0000. Writes to them change neither register.
- R9: cfg_conflict is 1 when at least one pin has its direction set to output and its pull-up enabled.
- R10: A read of offset 0 returns the full 16-bit word most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register interface and the synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset for the configuration word and the synchronizer |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Levels seen at the pins |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu_en | output | 8 | Per-pin pull-up enable, active high |
| cfg_conflict | output | 1 | At least one pin is driving with its pull-up on |

## Verification
The configuration path is tested with a set of words: all zero, all one, only the even bits, only the odd bits, a single low pin, and two mixed words that touch pin 7. Together these separate the direction field from the pull-up field, expose an inverted pull-up polarity, and show whether a pull-up is wrongly gated by direction. The mixed words show whether the conflict flag detects a single pin or only a whole-port pattern. The data path is tested with a driven value that differs from the pin levels, which tells a read of the pins from a read of the latch. A pin change is then observed one edge and two edges later, which pins down the synchronizer depth.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
  localparam int unsigned DEF_PINS   = 8;
  localparam int unsigned DEF_ADDR_W = 2;
  localparam int unsigned OFF_CFG    = 0;
  localparam int unsigned OFF_DATA   = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int unsigned N_PINS = 8,
  localparam int unsigned CFG_W = 2 * N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [N_PINS-1:0] dir_out,
  output logic [N_PINS-1:0] pu_on,
  output logic              conflict
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end

  // Unpack the interleaved fields: even bit = direction, odd bit = pull-up off
  for (genvar n = 0; n < N_PINS; n++) begin : g_unpack
    assign dir_out[n] = cfg_q[2*n];
    assign pu_on[n]   = ~cfg_q[2*n+1];
  end

  assign conflict = |(dir_out & pu_on);
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [N_PINS-1:0] wr_data,
  output logic [N_PINS-1:0] q
);
  // Deliberately has no reset: contents survive any reset
  always_ff @(posedge clk) begin
    if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] d,
  output logic [N_PINS-1:0] q
);
  logic [N_PINS-1:0] stage [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio8_pkg::*;
#(
  parameter int unsigned N_PINS = DEF_PINS,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned BUS_W = 2 * N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_pu_en,
  output logic              cfg_conflict
);
  reg_sel_e          sel;
  logic [BUS_W-1:0]  cfg_word;
  logic [N_PINS-1:0] pin_sync;

  always_comb begin
    if (bus_addr == ADDR_W'(OFF_CFG))       sel = SEL_CFG;
    else if (bus_addr == ADDR_W'(OFF_DATA)) sel = SEL_DATA;
    else                                    sel = SEL_NONE;
  end

  gpio_cfg_reg #(.N_PINS(N_PINS)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we && sel == SEL_CFG),
    .wr_data  (bus_wdata),
    .cfg_q    (cfg_word),
    .dir_out  (pad_oe),
    .pu_on    (pad_pu_en),
    .conflict (cfg_conflict)
  );

  gpio_out_latch #(.N_PINS(N_PINS)) u_latch (
    .clk     (clk),
    .wr_en   (bus_we && sel == SEL_DATA),
    .wr_data (bus_wdata[N_PINS-1:0]),
    .q       (pad_out)
  );

  gpio_in_sync #(.N_PINS(N_PINS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  always_comb begin
    unique case (sel)
      SEL_CFG:  bus_rdata = cfg_word;
      SEL_DATA: bus_rdata = BUS_W'(pin_sync);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int unsigned N_PINS = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned BUS_W = 2 * N_PINS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [N_PINS-1:0] pin_in,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pad_out,
  input logic [N_PINS-1:0] pad_pu_en,
  input logic              cfg_conflict
);
  function automatic logic [N_PINS-1:0] even_bits(input logic [BUS_W-1:0] v);
    logic [N_PINS-1:0] r;
    for (int i = 0; i < N_PINS; i++) r[i] = v[2*i];
    return r;
  endfunction

  function automatic logic [N_PINS-1:0] odd_bits(input logic [BUS_W-1:0] v);
    logic [N_PINS-1:0] r;
    for (int i = 0; i < N_PINS; i++) r[i] = v[2*i+1];
    return r;
  endfunction

  logic       first_q;
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      age_q   <= '0;
    end else begin
      first_q <= 1'b0;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  wire cfg_wr  = bus_we && bus_addr == ADDR_W'(0);
  wire data_wr = bus_we && bus_addr == ADDR_W'(2);

  assert_reset_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> (pad_oe == '0 && pad_pu_en == '1 && !cfg_conflict));

  assert_dir_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pad_oe == even_bits($past(bus_wdata)));

  assert_pullup_active_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pad_pu_en == ~odd_bits($past(bus_wdata)));

  assert_latch_drives_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> pad_out == $past(bus_wdata[N_PINS-1:0]));

  assert_read_is_synced_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && bus_addr == ADDR_W'(2)) |->
      bus_rdata == BUS_W'($past(pin_in, 2)));

  assert_odd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[0] |-> bus_rdata == '0);

  assert_odd_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[0]) |=>
      ($stable(pad_oe) && $stable(pad_pu_en) && $stable(pad_out)));

  assert_conflict_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_conflict ==
      (|(even_bits($past(bus_wdata)) & ~odd_bits($past(bus_wdata)))));
endmodule

bind gpio_port8 gpio_port8_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .pin_in       (pin_in),
  .pad_oe       (pad_oe),
  .pad_out      (pad_out),
  .pad_pu_en    (pad_pu_en),
  .cfg_conflict (cfg_conflict)
);

// File: tb/gpio_port8_tb.sv
module gpio_port8_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  pin_in = 8'h0F;
  logic [7:0]  pad_oe, pad_out, pad_pu_en;
  logic        cfg_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port8 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu_en(pad_pu_en),
    .cfg_conflict(cfg_conflict)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [7:0]  oe;
    logic [7:0]  pu;
    logic        cf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{16'h0000, 8'h00, 8'hFF, 1'b0},
    '{16'hFFFF, 8'hFF, 8'h00, 1'b0},
    '{16'h5555, 8'hFF, 8'hFF, 1'b1},
    '{16'hAAAA, 8'h00, 8'h00, 1'b0},
    '{16'h0001, 8'h01, 8'hFF, 1'b1},
    '{16'h8003, 8'h01, 8'h7E, 1'b0},
    '{16'h4000, 8'h80, 8'hFF, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    check("R2 pad_oe", {8'h0, pad_oe}, 16'h0000);
    check("R2 pad_pu_en", {8'h0, pad_pu_en}, 16'h00FF);
    check("R2 conflict", {15'h0, cfg_conflict}, 16'h0000);
    rd_check("R2 cfg read", 2'd0, 16'h0000);

    // R1 R3 R4 R9 R10: configuration vectors
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i].cfg);
      check("R3 pad_oe", {8'h0, pad_oe}, {8'h0, VEC[i].oe});
      check("R4 pad_pu_en", {8'h0, pad_pu_en}, {8'h0, VEC[i].pu});
      check("R9 conflict", {15'h0, cfg_conflict}, {15'h0, VEC[i].cf});
      rd_check("R10 R1 cfg readback", 2'd0, VEC[i].cfg);
    end

    // R5: data latch drives pads, upper byte ignored
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h3CA5);
    check("R5 pad_out", {8'h0, pad_out}, 16'h00A5);

    // R6: read returns synced pin levels (0x0F), not the latch (0xA5)
    rd_check("R6 read pins not latch", 2'd2, 16'h000F);
    pin_in = 8'hF0;
    @(negedge clk);
    rd_check("R6 one edge later old value", 2'd2, 16'h000F);
    @(negedge clk);
    rd_check("R6 two edges later new value", 2'd2, 16'h00F0);

    // R8: odd offsets read zero, writes ignored
    rd_check("R8 read offset 1", 2'd1, 16'h0000);
    rd_check("R8 read offset 3", 2'd3, 16'h0000);
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'h005A);
    rd_check("R8 cfg unchanged", 2'd0, 16'hFFFF);
    check("R8 pad_out unchanged", {8'h0, pad_out}, 16'h00A5);

    // R7: latch survives reset, configuration clears
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 pad_out kept", {8'h0, pad_out}, 16'h00A5);
    rd_check("R2 cfg cleared", 2'd0, 16'h0000);
    check("R2 pad_oe after reset", {8'h0, pad_oe}, 16'h0000);

    finish_run();
  end
endmodule